// File: doc/BRIEF.md
# Time-Multiplexed Second-Order Recursive Filter

This block is a second-order recursive filter for one channel of 16-bit signed samples. A direct implementation would use six multipliers and four adders. Here one pipelined constant multiplier and one adder do all of that work under a fixed cyclic schedule of six clock cycles per sample. A slot counter runs freely and steps through the schedule.

Products that are consumed within a cycle of being produced flow straight through pipeline registers. The two products that must wait longer are parked in a two-entry holding register file. The schedule is cyclic: the last two additions of one sample run in the first two slots of the next period. The feedback sum is complete before the new state value is formed, so the recursion closes inside one period.

A producer watches `in_ready`. That signal is high for one cycle in every six. A sample offered with `in_valid` in that cycle is taken; at any other time `in_valid` is ignored. Periods in which no sample is taken leave the filter state untouched.

Top module: `iir2_tm_filter`

## Requirements
- R1: After reset is released, `out_valid` stays low. `in_ready` is high in exactly one cycle of every six, and it is first high in the sixth cycle after release.
- R2: A sample is taken only in a cycle where `in_valid` and `in_ready` are both high. Raising `in_valid` in any other cycle changes neither the filter state nor the output.
- R3: All coefficients are signed Q4.12: feed-in 20480, feedback 1229 and 819, feed-forward 2867, 1638 and 2458. Each product is coefficient times operand, shifted right arithmetically by 12. For a taken sample x, the new state is w = P(20480,x) + (P(1229,w1) + P(819,w2)), where w1 is the state from one taken sample back and w2 the state from two taken samples back, all kept at 24 bits.
- R4: The output for a taken sample is y = P(2867,w) + (P(1638,w1) + P(2458,w2)), using the same w1 and w2 as R3. It is clipped to the range -32768 to 32767.
- R5: For a sample taken in cycle k, `out_valid` is high in cycle k+10, for that cycle only, with that sample's result on `out_data`. `out_data` holds its value whenever `out_valid` is low.
- R6: A six-cycle period in which no sample is taken produces no `out_valid` pulse and does not shift w1 or w2. Exactly one output is produced per taken sample.
- R7: Asserting reset clears both state delays and the schedule counter. After reset, an impulse gives the same response as it would from power-up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample offered on in_data |
| in_data | input | 16 | Signed input sample |
| in_ready | output | 1 | High in the one cycle of each period in which a sample is taken |
| out_valid | output | 1 | One-cycle strobe marking a new result |
| out_data | output | 16 | Clipped signed filter output |

## Verification
The impulse response shows whether the recursion closes inside one period. A design that updated the delays late, or read w1 after it had shifted, would give a response that drifts away from the reference after the first few samples. Gaps of whole empty periods catch a design that shifts its state or pulses `out_valid` without a sample. Valid strobes placed outside the `in_ready` cycle catch a design that samples the input on the wrong slot. Long runs of near-full-scale input drive the output far past 16 bits, which exposes wrap-around in place of clipping. A reset in the middle of the run, followed by a second impulse, shows whether any state survives reset.

// File: rtl/iir2_pkg.sv
package iir2_pkg;

  // schedule length: six products share one multiplier
  localparam int PERIOD     = 6;
  localparam int SLOT_W     = $clog2(PERIOD);
  localparam int NUM_COEF   = 6;
  localparam int HOLD_DEPTH = 2;
  localparam int HOLD_AW    = (HOLD_DEPTH > 1) ? $clog2(HOLD_DEPTH) : 1;

  // coefficient index; order fixes the packing of the coefficient vector
  typedef enum logic [2:0] {
    CF_X   = 3'd0,
    CF_FB1 = 3'd1,
    CF_FB2 = 3'd2,
    CF_FF0 = 3'd3,
    CF_FF1 = 3'd4,
    CF_FF2 = 3'd5
  } coef_sel_e;

  typedef enum logic [1:0] {
    MS_W1  = 2'd0,
    MS_W2  = 2'd1,
    MS_X   = 2'd2,
    MS_SUM = 2'd3
  } mul_src_e;

  typedef enum logic {
    AA_HOLD = 1'b0,
    AA_SUM  = 1'b1
  } add_a_e;

  typedef struct packed {
    coef_sel_e            coef;
    mul_src_e             msrc;
    logic                 add_en;
    add_a_e               asrc;
    logic [HOLD_AW-1:0]   raddr;
    logic                 hold_we;
    logic [HOLD_AW-1:0]   waddr;
    logic                 state_upd;
    logic                 out_cap;
  } step_t;

  // Control word for each slot. Products appear two slots after issue and
  // sums one slot after issue.
  function automatic step_t step_for(input logic [SLOT_W-1:0] s);
    step_t st;
    st = '0;
    case (s)
      SLOT_W'(0): begin  // w1*fb1 ; tail: a3 = p_ff1 + p_ff2
        st.coef = CF_FB1; st.msrc = MS_W1;
        st.add_en = 1'b1; st.asrc = AA_HOLD; st.raddr = HOLD_AW'(1);
      end
      SLOT_W'(1): begin  // w2*fb2 ; tail: y = a3 + p_ff0
        st.coef = CF_FB2; st.msrc = MS_W2;
        st.add_en = 1'b1; st.asrc = AA_SUM;
      end
      SLOT_W'(2): begin  // x*cx ; park p_fb1 ; capture y
        st.coef = CF_X; st.msrc = MS_X;
        st.hold_we = 1'b1; st.waddr = HOLD_AW'(0);
        st.out_cap = 1'b1;
      end
      SLOT_W'(3): begin  // w1*ff1 ; fb = p_fb1 + p_fb2
        st.coef = CF_FF1; st.msrc = MS_W1;
        st.add_en = 1'b1; st.asrc = AA_HOLD; st.raddr = HOLD_AW'(0);
      end
      SLOT_W'(4): begin  // w2*ff2 ; w = fb + p_x
        st.coef = CF_FF2; st.msrc = MS_W2;
        st.add_en = 1'b1; st.asrc = AA_SUM;
      end
      SLOT_W'(5): begin  // w*ff0 ; park p_ff1 ; shift state
        st.coef = CF_FF0; st.msrc = MS_SUM;
        st.hold_we = 1'b1; st.waddr = HOLD_AW'(1);
        st.state_upd = 1'b1;
      end
      default: st = '0;
    endcase
    return st;
  endfunction

endpackage

// File: rtl/iir2_seq.sv
module iir2_seq
  import iir2_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  in_valid,
  output logic  in_ready,
  output logic  take,
  output logic  cur_vld,
  output logic  prev_vld,
  output step_t step
);

  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              cur_q, cur_d;
  logic              prev_q, prev_d;
  logic              wrap;

  always_comb begin
    wrap     = (slot_q == SLOT_W'(PERIOD - 1));
    in_ready = wrap;
    take     = wrap & in_valid;
    slot_d   = wrap ? '0 : slot_q + SLOT_W'(1);
    cur_d    = wrap ? take  : cur_q;
    prev_d   = wrap ? cur_q : prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      cur_q  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      slot_q <= slot_d;
      cur_q  <= cur_d;
      prev_q <= prev_d;
    end
  end

  assign cur_vld  = cur_q;
  assign prev_vld = prev_q;
  assign step     = step_for(slot_q);

endmodule

// File: rtl/iir2_cmul.sv
module iir2_cmul
  import iir2_pkg::*;
#(
  parameter int OP_W    = 24,
  parameter int COEF_W  = 16,
  parameter int FRAC    = 12,
  parameter logic [NUM_COEF*COEF_W-1:0] COEF_VEC = '0
) (
  input  logic                   clk,
  input  coef_sel_e              sel,
  input  logic signed [OP_W-1:0] op,
  output logic signed [OP_W-1:0] res
);

  localparam int PROD_W = OP_W + COEF_W;
  localparam int TAB_N  = 2 ** $bits(coef_sel_e);

  logic signed [COEF_W-1:0] coef_tab [TAB_N];

  for (genvar i = 0; i < TAB_N; i++) begin : g_tab
    if (i < NUM_COEF) begin : g_used
      assign coef_tab[i] = COEF_VEC[i*COEF_W +: COEF_W];
    end else begin : g_spare
      assign coef_tab[i] = '0;
    end
  end

  logic signed [PROD_W-1:0] prod_d, prod_q;
  logic signed [OP_W-1:0]   res_d, res_q;

  always_comb begin
    prod_d = coef_tab[sel] * op;
    res_d  = OP_W'(prod_q >>> FRAC);
  end

  // stage 1: raw product ; stage 2: scaled product
  always_ff @(posedge clk) begin
    prod_q <= prod_d;
    res_q  <= res_d;
  end

  assign res = res_q;

endmodule

// File: rtl/iir2_add.sv
module iir2_add
  import iir2_pkg::*;
#(
  parameter int W = 24
) (
  input  logic                clk,
  input  logic                en,
  input  add_a_e              asrc,
  input  logic signed [W-1:0] hold_rd,
  input  logic signed [W-1:0] b,
  output logic signed [W-1:0] sum
);

  logic signed [W-1:0] a, sum_d, sum_q;

  always_comb begin
    a     = (asrc == AA_HOLD) ? hold_rd : sum_q;
    sum_d = a + b;
  end

  always_ff @(posedge clk) begin
    if (en) sum_q <= sum_d;
  end

  assign sum = sum_q;

endmodule

// File: rtl/iir2_hold.sv
module iir2_hold
  import iir2_pkg::*;
#(
  parameter int W = 24
) (
  input  logic                clk,
  input  logic                we,
  input  logic [HOLD_AW-1:0]  waddr,
  input  logic signed [W-1:0] wdata,
  input  logic [HOLD_AW-1:0]  raddr,
  output logic signed [W-1:0] rdata
);

  logic signed [W-1:0] ent [HOLD_DEPTH];

  for (genvar i = 0; i < HOLD_DEPTH; i++) begin : g_ent
    logic signed [W-1:0] q;
    always_ff @(posedge clk) begin
      if (we && (waddr == HOLD_AW'(i))) q <= wdata;
    end
    assign ent[i] = q;
  end

  assign rdata = ent[raddr];

endmodule

// File: rtl/iir2_tm_filter.sv
module iir2_tm_filter
  import iir2_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 24,
  parameter int COEF_W = 16,
  parameter int FRAC   = 12,
  parameter int C_X    = 20480,
  parameter int C_FB1  = 1229,
  parameter int C_FB2  = 819,
  parameter int C_FF0  = 2867,
  parameter int C_FF1  = 1638,
  parameter int C_FF2  = 2458
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);

  localparam logic [NUM_COEF*COEF_W-1:0] COEF_VEC = {
    COEF_W'(C_FF2), COEF_W'(C_FF1), COEF_W'(C_FF0),
    COEF_W'(C_FB2), COEF_W'(C_FB1), COEF_W'(C_X)
  };
  localparam logic signed [ACC_W-1:0] Y_HI = ACC_W'(2 ** (DATA_W - 1) - 1);
  localparam logic signed [ACC_W-1:0] Y_LO = -Y_HI - ACC_W'(1);

  step_t step;
  logic  take, cur_vld, prev_vld;

  iir2_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .take     (take),
    .cur_vld  (cur_vld),
    .prev_vld (prev_vld),
    .step     (step)
  );

  // input sample register and the two state delays
  logic signed [DATA_W-1:0] x_q;
  logic signed [ACC_W-1:0]  w1_q, w1_d, w2_q, w2_d;
  logic signed [ACC_W-1:0]  sum, mres, hold_rd, mul_op;
  logic                     upd;

  always_ff @(posedge clk) begin
    if (take) x_q <= $signed(in_data);
  end

  always_comb begin
    upd  = step.state_upd & cur_vld;
    w1_d = upd ? sum  : w1_q;
    w2_d = upd ? w1_q : w2_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w1_q <= '0;
      w2_q <= '0;
    end else begin
      w1_q <= w1_d;
      w2_q <= w2_d;
    end
  end

  // operand routing into the shared multiplier
  always_comb begin
    case (step.msrc)
      MS_W1:   mul_op = w1_q;
      MS_W2:   mul_op = w2_q;
      MS_X:    mul_op = ACC_W'(x_q);
      default: mul_op = sum;
    endcase
  end

  iir2_cmul #(
    .OP_W     (ACC_W),
    .COEF_W   (COEF_W),
    .FRAC     (FRAC),
    .COEF_VEC (COEF_VEC)
  ) u_cmul (
    .clk (clk),
    .sel (step.coef),
    .op  (mul_op),
    .res (mres)
  );

  iir2_hold #(.W(ACC_W)) u_hold (
    .clk   (clk),
    .we    (step.hold_we),
    .waddr (step.waddr),
    .wdata (mres),
    .raddr (step.raddr),
    .rdata (hold_rd)
  );

  iir2_add #(.W(ACC_W)) u_add (
    .clk     (clk),
    .en      (step.add_en),
    .asrc    (step.asrc),
    .hold_rd (hold_rd),
    .b       (mres),
    .sum     (sum)
  );

  // clip and output registers
  logic              cap;
  logic [DATA_W-1:0] y_clip, out_q, out_d;
  logic              ov_q;

  always_comb begin
    cap = step.out_cap & prev_vld;
    if (sum > Y_HI)      y_clip = DATA_W'(Y_HI);
    else if (sum < Y_LO) y_clip = DATA_W'(Y_LO);
    else                 y_clip = DATA_W'(sum);
    out_d = cap ? y_clip : out_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_q  <= 1'b0;
      out_q <= '0;
    end else begin
      ov_q  <= cap;
      out_q <= out_d;
    end
  end

  assign out_valid = ov_q;
  assign out_data  = out_q;

endmodule

// File: rtl/iir2_tm_filter_chk.sv
module iir2_tm_filter_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data
);

  // R1
  ready_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> !in_ready);

  // R1
  ready_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> ##6 in_ready);

  // R5
  out_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R5
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> ##10 out_valid);

  // R2
  out_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid && in_ready, 10));

  // R5
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));

endmodule

bind iir2_tm_filter iir2_tm_filter_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/iir2_tm_filter_bench.sv
module iir2_tm_filter_bench;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [15:0] in_data;
  logic        in_ready;
  logic        out_valid;
  logic [15:0] out_data;

  iir2_tm_filter u_iir2_tm_filter (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int    n_chk  = 0;
  int    n_fail = 0;
  int    cyc    = 0;
  string tag    = "R3";
  bit    done   = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- reference model (R3, R4) ----------------
  longint m_w1 = 0, m_w2 = 0;

  function automatic longint wrap24(input longint v);
    return (v <<< 40) >>> 40;
  endfunction

  function automatic longint pq(input longint c, input longint v);
    return wrap24((c * v) >>> 12);
  endfunction

  function automatic longint model_step(input longint x);
    longint w, y;
    w = wrap24(pq(20480, x) + wrap24(pq(1229, m_w1) + pq(819, m_w2)));
    y = wrap24(pq(2867, w) + wrap24(pq(1638, m_w1) + pq(2458, m_w2)));
    m_w2 = m_w1;
    m_w1 = w;
    if (y > 32767)  y = 32767;
    if (y < -32768) y = -32768;
    return y;
  endfunction

  longint exp_q[$];
  int     acc_q[$];
  int     n_taken = 0;
  int     n_out   = 0;

  // ---------------- monitor at the falling edge ----------------
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (in_valid && in_ready) begin
        exp_q.push_back(model_step(longint'($signed(in_data))));
        acc_q.push_back(cyc);
        n_taken++;
      end
      if (out_valid) begin
        n_out++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R6", "output without a taken sample", 1, 0);
        end else begin
          longint e;
          int     a;
          e = exp_q.pop_front();
          a = acc_q.pop_front();
          check(longint'($signed(out_data)) == e, tag, "out_data",
                longint'($signed(out_data)), e);
          check(cyc - a == 10, "R5", "latency", cyc - a, 10);
        end
      end
    end
  end

  // ---------------- drivers ----------------
  task automatic send(input int v, input bit noisy);
    forever begin
      @(posedge clk); #1;
      if (in_ready) break;
      in_valid = noisy;
      in_data  = 16'($urandom);
    end
    in_valid = 1'b1;
    in_data  = 16'(v);
    @(posedge clk); #1;
    in_valid = 1'b0;
    in_data  = 16'($urandom);
  endtask

  task automatic idle_periods(input int n);
    repeat (n * 6) @(posedge clk);
    #1;
  endtask

  task automatic reset_and_check_r1();
    rst_n = 1'b0;
    m_w1  = 0;
    m_w2  = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); #1;
      check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
      check(in_ready == (k == 5), "R1", "in_ready slot", in_ready, (k == 5));
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    int seed_val;
    seed_val = $urandom(32'h1ee7);
    in_valid = 1'b0;
    in_data  = '0;
    reset_and_check_r1();

    // R3: impulse response
    tag = "R3";
    send(1000, 1'b0);
    for (int i = 0; i < 24; i++) send(0, 1'b0);

    // R3: random back-to-back samples
    for (int i = 0; i < 60; i++) send($signed(12'($urandom)) * 2 + 1, 1'b0);

    // R6: empty periods between samples must not shift the state
    tag = "R6";
    for (int i = 0; i < 30; i++) begin
      idle_periods(int'($urandom_range(0, 3)));
      send($signed(12'($urandom)), 1'b0);
    end

    // R2: valid strobes outside the ready cycle
    tag = "R2";
    for (int i = 0; i < 30; i++) send($signed(12'($urandom)), 1'b1);

    // R4: large inputs push the output into both clip limits
    tag = "R4";
    for (int i = 0; i < 25; i++) send(30000, 1'b0);
    for (int i = 0; i < 25; i++) send(-30000, 1'b0);
    for (int i = 0; i < 10; i++) send(0, 1'b0);
    idle_periods(4);
    check(exp_q.size() == 0, "R6", "outputs pending before reset", exp_q.size(), 0);

    // R7: reset mid-run, then the impulse again
    reset_and_check_r1();
    tag = "R7";
    send(1000, 1'b0);
    for (int i = 0; i < 12; i++) send(0, 1'b0);
    send(-32768, 1'b0);
    send(32767, 1'b0);
    idle_periods(4);

    check(exp_q.size() == 0, "R6", "outputs still pending", exp_q.size(), 0);
    check(n_out == n_taken, "R6", "output count", n_out, n_taken);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule